// File: doc/BRIEF.md
# Low-Power State Sequencer

This block decides when a processor subsystem leaves normal operation for one of two sleep states, and when it comes back. A shallow sleep state keeps the core supply on and gates the high-speed clocks. A deep sleep state turns the core regulator off as well. The block takes a wait request from the core, either "wait for interrupt" or "wait for event", together with three software control bits. It refuses to sleep while any external-line pending flag or the alarm flag is still set. While asleep it watches for the wake sources that apply to the current state.

Leaving deep sleep always goes through a recovery state. In that state a domain-reset pulse of fixed length restarts the core logic as if from reset. A retained standby flag records that deep sleep happened. Only power-on reset or a software clear bit clears this flag. The controller itself sits in the always-on domain and is cleared only by power-on reset.

Top module: `lpm_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `pwr_state` is 0 (RUN), `reg_en` is 1, `core_off`, `clk_off`, `reg_lp` and `dom_rst` are 0, and `sb_flag` is 0.
- R2: `pwr_state` encodes the state as RUN=0, STOP=1, STBY=2, RECOV=3. A one-cycle `wait_irq` or `wait_evt` in RUN moves the block to STOP one clock later when `cfg_deep`=1 and `cfg_pdds`=0. It moves to STBY when `cfg_deep`=1 and `cfg_pdds`=1. With `cfg_deep`=0 it stays in RUN.
- R3: A wait request is ignored, and the state stays RUN, whenever any bit of `line_pend` or `alarm_flag` is 1 in the request cycle.
- R4: In STOP entered through `wait_irq`, the block returns to RUN one clock after a cycle in which some bit is 1 in both `line_irq` and `irq_en`. A `line_irq` bit whose `irq_en` bit is 0, or any `line_evt`, leaves it in STOP.
- R5: In STOP entered through `wait_evt`, any `line_evt` bit returns the block to RUN one clock later. `line_irq` leaves it in STOP, whatever `irq_en` holds.
- R6: The outputs depend on the state:
  - In STBY: `reg_en`=0, `core_off`=1, `clk_off`=1.
  - In STOP: `reg_en`=1, `core_off`=0, `clk_off`=1, and `reg_lp` equals `cfg_lpreg` as sampled in the entry cycle.
  - In RUN: `reg_en`=1 and the other power outputs are 0.
- R7: STBY moves to RECOV one clock after any of `ext_rst`, `wdg_rst` or `alarm_evt`. It also moves to RECOV on a rising edge of the asynchronous `wake_pin`:
  - After a rise on `wake_pin`, RECOV is entered at the third rising clock edge.
  - A rise on `wake_pin` outside STBY has no effect.
  - A pin that is already high when STBY is entered is not a wake.
- R8: RECOV holds `dom_rst`=1 for exactly RST_LEN cycles, then returns to RUN with `dom_rst`=0.
- R9: Leaving STBY sets `sb_flag`. The flag survives every later domain reset and is cleared only by `flag_clr` (one clock later) or by power-on reset.
- R10: `ext_rst` or `wdg_rst` in RUN or STOP moves the block to RECOV one clock later without changing `sb_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wait_irq | input | 1 | Core wait-for-interrupt request |
| wait_evt | input | 1 | Core wait-for-event request |
| cfg_deep | input | 1 | Deep-sleep select |
| cfg_pdds | input | 1 | Power-down select (STBY instead of STOP) |
| cfg_lpreg | input | 1 | Low-power regulator select for STOP |
| line_pend | input | N_LINES | External-line pending flags |
| alarm_flag | input | 1 | Alarm pending flag |
| line_irq | input | N_LINES | External-line interrupt requests |
| irq_en | input | N_LINES | Per-line interrupt enables |
| line_evt | input | N_LINES | External-line event requests |
| wake_pin | input | 1 | Asynchronous wake pin |
| alarm_evt | input | 1 | Alarm event |
| ext_rst | input | 1 | External reset request |
| wdg_rst | input | 1 | Watchdog reset request |
| flag_clr | input | 1 | Software clear of the standby flag |
| pwr_state | output | 2 | Current state code |
| reg_en | output | 1 | Regulator enable |
| reg_lp | output | 1 | Regulator low-power mode |
| core_off | output | 1 | Core domain powered off |
| clk_off | output | 1 | PLL and high-speed oscillators disabled |
| dom_rst | output | 1 | Core domain reset |
| sb_flag | output | 1 | Retained standby flag |

## Verification
The bench builds the block with N_LINES=3, RST_LEN=3 and SYNC_STAGES=2. With three lines, every pending pattern can be swept against both alarm states, both wait kinds and all deep/power-down selections. Every line can also be tried as a wake source under each wait kind. The short reset length and two-stage synchronizer make the recovery pulse width and the wake-pin latency exact, countable cycle figures.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_STOP  = 2'd1,
      PS_STBY  = 2'd2,
      PS_RECOV = 2'd3
   } pstate_t;
endpackage

// File: rtl/lpm_wake_edge.sv
module lpm_wake_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin,
   output logic rise
);
   logic [STAGES-1:0] sq;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("lpm_wake_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sq   <= '0;
         last <= 1'b0;
      end else begin
         sq   <= {sq[STAGES-2:0], pin};
         last <= sq[STAGES-1];
      end
   end

   assign rise = sq[STAGES-1] & ~last;
endmodule

// File: rtl/lpm_entry_gate.sv
module lpm_entry_gate #(
   parameter int N_LINES = 4
) (
   input  lpm_pkg::pstate_t     state,
   input  logic                 wait_irq,
   input  logic                 wait_evt,
   input  logic                 cfg_deep,
   input  logic                 cfg_pdds,
   input  logic [N_LINES-1:0]   line_pend,
   input  logic                 alarm_flag,
   output logic                 go_stop,
   output logic                 go_stby
);
   import lpm_pkg::*;
   logic blocked, req;

   always_comb begin
      blocked = (|line_pend) | alarm_flag;
      req     = (state == PS_RUN) & (wait_irq | wait_evt) & cfg_deep & ~blocked;
      go_stop = req & ~cfg_pdds;
      go_stby = req & cfg_pdds;
   end
endmodule

// File: rtl/lpm_exit_dec.sv
module lpm_exit_dec #(
   parameter int N_LINES = 4
) (
   input  lpm_pkg::pstate_t     state,
   input  logic                 via_evt,
   input  logic [N_LINES-1:0]   line_irq,
   input  logic [N_LINES-1:0]   irq_en,
   input  logic [N_LINES-1:0]   line_evt,
   input  logic                 ext_rst,
   input  logic                 wdg_rst,
   input  logic                 alarm_evt,
   input  logic                 wake_rise,
   output logic                 stop_wake,
   output logic                 stby_wake,
   output logic                 hard_rst
);
   import lpm_pkg::*;
   logic irq_hit, evt_hit;

   always_comb begin
      irq_hit   = |(line_irq & irq_en);
      evt_hit   = |line_evt;
      hard_rst  = ext_rst | wdg_rst;
      stop_wake = (state == PS_STOP) & (via_evt ? evt_hit : irq_hit);
      stby_wake = (state == PS_STBY) & (hard_rst | alarm_evt | wake_rise);
   end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
   parameter int N_LINES     = 4,
   parameter int RST_LEN     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               wait_irq,
   input  logic               wait_evt,
   input  logic               cfg_deep,
   input  logic               cfg_pdds,
   input  logic               cfg_lpreg,
   input  logic [N_LINES-1:0] line_pend,
   input  logic               alarm_flag,
   input  logic [N_LINES-1:0] line_irq,
   input  logic [N_LINES-1:0] irq_en,
   input  logic [N_LINES-1:0] line_evt,
   input  logic               wake_pin,
   input  logic               alarm_evt,
   input  logic               ext_rst,
   input  logic               wdg_rst,
   input  logic               flag_clr,
   output logic [1:0]         pwr_state,
   output logic               reg_en,
   output logic               reg_lp,
   output logic               core_off,
   output logic               clk_off,
   output logic               dom_rst,
   output logic               sb_flag
);
   import lpm_pkg::*;

   localparam int CW = $clog2(RST_LEN + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(RST_LEN - 1);

   generate
      if (N_LINES < 1) begin : g_bad_lines
         $error("lpm_ctrl: N_LINES must be at least 1");
      end
      if (RST_LEN < 1) begin : g_bad_len
         $error("lpm_ctrl: RST_LEN must be at least 1");
      end
   endgenerate

   pstate_t       state, state_nx;
   logic          via_evt, lp_hold;
   logic [CW-1:0] cnt;
   logic          go_stop, go_stby, stop_wake, stby_wake, hard_rst, wake_rise;

   lpm_wake_edge #(.STAGES(SYNC_STAGES)) u_wake (
      .clk(clk), .por_n(por_n), .pin(wake_pin), .rise(wake_rise)
   );

   lpm_entry_gate #(.N_LINES(N_LINES)) u_entry (
      .state(state), .wait_irq(wait_irq), .wait_evt(wait_evt),
      .cfg_deep(cfg_deep), .cfg_pdds(cfg_pdds), .line_pend(line_pend),
      .alarm_flag(alarm_flag), .go_stop(go_stop), .go_stby(go_stby)
   );

   lpm_exit_dec #(.N_LINES(N_LINES)) u_exit (
      .state(state), .via_evt(via_evt), .line_irq(line_irq), .irq_en(irq_en),
      .line_evt(line_evt), .ext_rst(ext_rst), .wdg_rst(wdg_rst),
      .alarm_evt(alarm_evt), .wake_rise(wake_rise),
      .stop_wake(stop_wake), .stby_wake(stby_wake), .hard_rst(hard_rst)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         PS_RUN: begin
            if (hard_rst)     state_nx = PS_RECOV;
            else if (go_stby) state_nx = PS_STBY;
            else if (go_stop) state_nx = PS_STOP;
         end
         PS_STOP: begin
            if (hard_rst)       state_nx = PS_RECOV;
            else if (stop_wake) state_nx = PS_RUN;
         end
         PS_STBY: begin
            if (stby_wake) state_nx = PS_RECOV;
         end
         PS_RECOV: begin
            if (!hard_rst && cnt == '0) state_nx = PS_RUN;
         end
         default: state_nx = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state   <= PS_RUN;
         via_evt <= 1'b0;
         lp_hold <= 1'b0;
         cnt     <= '0;
         sb_flag <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == PS_RUN && go_stop) begin
            via_evt <= ~wait_irq;
            lp_hold <= cfg_lpreg;
         end
         if (state_nx == PS_RECOV && (state != PS_RECOV || hard_rst))
            cnt <= CNT_LOAD;
         else if (state == PS_RECOV && cnt != '0)
            cnt <= cnt - 1'b1;
         if (stby_wake)     sb_flag <= 1'b1;
         else if (flag_clr) sb_flag <= 1'b0;
      end
   end

   assign pwr_state = state;
   assign reg_en    = (state != PS_STBY);
   assign core_off  = (state == PS_STBY);
   assign clk_off   = (state == PS_STOP) || (state == PS_STBY);
   assign reg_lp    = (state == PS_STOP) && lp_hold;
   assign dom_rst   = (state == PS_RECOV);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int N_LINES = 4
) (
   input logic               clk,
   input logic               por_n,
   input logic               wait_irq,
   input logic               wait_evt,
   input logic               cfg_deep,
   input logic               cfg_pdds,
   input logic [N_LINES-1:0] line_pend,
   input logic               alarm_flag,
   input logic [N_LINES-1:0] line_irq,
   input logic [N_LINES-1:0] line_evt,
   input logic               alarm_evt,
   input logic               ext_rst,
   input logic               wdg_rst,
   input logic               flag_clr,
   input logic [1:0]         pwr_state,
   input logic               reg_en,
   input logic               reg_lp,
   input logic               core_off,
   input logic               clk_off,
   input logic               dom_rst,
   input logic               sb_flag
);
   logic no_rst, clear_ok;
   assign no_rst   = !ext_rst && !wdg_rst;
   assign clear_ok = (line_pend == '0) && !alarm_flag;

   p_entry_stop_r2: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state == 2'd0 && (wait_irq || wait_evt) && cfg_deep && !cfg_pdds && clear_ok && no_rst)
      |=> pwr_state == 2'd1);

   p_entry_stby_r2: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state == 2'd0 && (wait_irq || wait_evt) && cfg_deep && cfg_pdds && clear_ok && no_rst)
      |=> pwr_state == 2'd2);

   p_refuse_r3: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state == 2'd0 && !clear_ok && no_rst) |=> pwr_state == 2'd0);

   p_stop_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state == 2'd1 && line_irq == '0 && line_evt == '0 && no_rst) |=> pwr_state == 2'd1);

   p_stby_power_r6: assert property (@(posedge clk) disable iff (!por_n)
      pwr_state == 2'd2 |-> (!reg_en && core_off && clk_off));

   p_run_power_r6: assert property (@(posedge clk) disable iff (!por_n)
      pwr_state == 2'd0 |-> (reg_en && !core_off && !clk_off && !reg_lp && !dom_rst));

   p_stby_exit_r7: assert property (@(posedge clk) disable iff (!por_n)
      (pwr_state == 2'd2 && (ext_rst || wdg_rst || alarm_evt)) |=> (pwr_state == 2'd3 && sb_flag));

   p_recov_end_r8: assert property (@(posedge clk) disable iff (!por_n)
      $fell(dom_rst) |-> pwr_state == 2'd0);

   p_flag_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
      (sb_flag && !flag_clr) |=> sb_flag);

   p_flag_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
      (flag_clr && pwr_state != 2'd2) |=> !sb_flag);

   p_hard_rst_r10: assert property (@(posedge clk) disable iff (!por_n)
      ((pwr_state == 2'd0 || pwr_state == 2'd1) && !no_rst) |=> pwr_state == 2'd3);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
   .clk(clk), .por_n(por_n), .wait_irq(wait_irq), .wait_evt(wait_evt),
   .cfg_deep(cfg_deep), .cfg_pdds(cfg_pdds), .line_pend(line_pend),
   .alarm_flag(alarm_flag), .line_irq(line_irq), .line_evt(line_evt),
   .alarm_evt(alarm_evt), .ext_rst(ext_rst), .wdg_rst(wdg_rst),
   .flag_clr(flag_clr), .pwr_state(pwr_state), .reg_en(reg_en),
   .reg_lp(reg_lp), .core_off(core_off), .clk_off(clk_off),
   .dom_rst(dom_rst), .sb_flag(sb_flag)
);

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
   localparam int NL = 3;
   localparam int RL = 3;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic wait_irq = 0, wait_evt = 0, cfg_deep = 0, cfg_pdds = 0, cfg_lpreg = 0;
   logic [NL-1:0] line_pend = '0, line_irq = '0, irq_en = '0, line_evt = '0;
   logic alarm_flag = 0, wake_pin = 0, alarm_evt = 0, ext_rst = 0, wdg_rst = 0, flag_clr = 0;
   logic [1:0] pwr_state;
   logic reg_en, reg_lp, core_off, clk_off, dom_rst, sb_flag;

   int n_chk = 0, n_fail = 0;
   logic exp_flag = 1'b0;

   always #10 clk = ~clk;

   lpm_ctrl #(.N_LINES(NL), .RST_LEN(RL), .SYNC_STAGES(2)) uut (
      .clk(clk), .por_n(por_n), .wait_irq(wait_irq), .wait_evt(wait_evt),
      .cfg_deep(cfg_deep), .cfg_pdds(cfg_pdds), .cfg_lpreg(cfg_lpreg),
      .line_pend(line_pend), .alarm_flag(alarm_flag), .line_irq(line_irq),
      .irq_en(irq_en), .line_evt(line_evt), .wake_pin(wake_pin),
      .alarm_evt(alarm_evt), .ext_rst(ext_rst), .wdg_rst(wdg_rst),
      .flag_clr(flag_clr), .pwr_state(pwr_state), .reg_en(reg_en),
      .reg_lp(reg_lp), .core_off(core_off), .clk_off(clk_off),
      .dom_rst(dom_rst), .sb_flag(sb_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_state(input int exp, input string req);
      check(pwr_state == exp, req, pwr_state, exp);
   endtask

   // Count the recovery pulse and land in RUN (R8)
   task automatic ride_recovery();
      int n = 0;
      while (dom_rst && n < 10) begin
         n++;
         step();
      end
      check(n == RL, "R8 pulse length", n, RL);
      chk_state(0, "R8 back to RUN");
   endtask

   task automatic go_home();
      if (pwr_state == 2) exp_flag = 1'b1;
      ext_rst = 1;
      step();
      ext_rst = 0;
      repeat (RL) step();
   endtask

   task automatic enter(input bit evt, input bit pdds, input bit lp);
      cfg_deep = 1; cfg_pdds = pdds; cfg_lpreg = lp;
      wait_irq = !evt; wait_evt = evt;
      step();
      wait_irq = 0; wait_evt = 0;
   endtask

   task automatic clear_flag();
      flag_clr = 1;
      step();
      flag_clr = 0;
      exp_flag = 1'b0;
      check(sb_flag == 0, "R9 flag cleared", sb_flag, 0);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1;
      @(negedge clk);
      // R1 reset state
      chk_state(0, "R1 state");
      check(reg_en && !core_off && !clk_off && !reg_lp && !dom_rst, "R1 outputs", reg_en, 1);
      check(sb_flag == 0, "R1 flag", sb_flag, 0);

      // R2 R3 R6 entry sweep
      for (int pv = 0; pv < (1 << NL); pv++)
         for (int al = 0; al < 2; al++)
            for (int kd = 0; kd < 2; kd++)
               for (int pd = 0; pd < 2; pd++)
                  for (int dp = 0; dp < 2; dp++) begin
                     int ex;
                     line_pend = NL'(pv); alarm_flag = al[0];
                     cfg_deep = dp[0]; cfg_pdds = pd[0]; cfg_lpreg = pv[0] ^ kd[0];
                     wait_irq = (kd == 0); wait_evt = (kd == 1);
                     step();
                     wait_irq = 0; wait_evt = 0; line_pend = '0; alarm_flag = 0;
                     ex = (dp == 1 && pv == 0 && al == 0) ? (pd == 1 ? 2 : 1) : 0;
                     chk_state(ex, (pv != 0 || al != 0) ? "R3 refused entry" : "R2 entry decode");
                     if (ex == 2)
                        check(!reg_en && core_off && clk_off, "R6 standby outputs", reg_en, 0);
                     else if (ex == 1)
                        check(reg_en && !core_off && clk_off && reg_lp == (pv[0] ^ kd[0]),
                              "R6 stop outputs", reg_lp, pv[0] ^ kd[0]);
                     else
                        check(reg_en && !core_off && !clk_off && !reg_lp, "R6 run outputs", clk_off, 0);
                     if (ex != 0) begin
                        go_home();
                        chk_state(0, "R2 return home");
                        check(sb_flag == exp_flag, "R9 flag after exit", sb_flag, exp_flag);
                        if (exp_flag) clear_flag();
                     end
                  end

      // R4 R5 stop exit sweep
      for (int kd = 0; kd < 2; kd++)
         for (int i = 0; i < NL; i++)
            for (int src = 0; src < 3; src++) begin
               bit wake;
               enter(kd[0], 1'b0, 1'b0);
               chk_state(1, "R2 stop entry");
               if (src == 2) line_evt = NL'(1 << i);
               else begin
                  line_irq = NL'(1 << i);
                  irq_en = (src == 1) ? NL'(1 << i) : ~NL'(1 << i);
               end
               step();
               line_evt = '0; line_irq = '0; irq_en = '0;
               wake = (kd == 0 && src == 1) || (kd == 1 && src == 2);
               chk_state(wake ? 0 : 1, kd == 0 ? "R4 irq-wait exit" : "R5 evt-wait exit");
               if (!wake) go_home();
            end

      // R10 watchdog reset in STOP
      enter(1'b0, 1'b0, 1'b1);
      wdg_rst = 1;
      step();
      wdg_rst = 0;
      chk_state(3, "R10 reset from STOP");
      ride_recovery();
      check(sb_flag == 0, "R10 flag untouched", sb_flag, 0);

      // R7 R8 R9 standby exits
      for (int src = 0; src < 4; src++) begin
         enter(src[0], 1'b1, 1'b0);
         chk_state(2, "R2 standby entry");
         case (src)
            0: ext_rst = 1;
            1: wdg_rst = 1;
            2: alarm_evt = 1;
            default: wake_pin = 1;
         endcase
         if (src == 3) begin
            step();
            chk_state(2, "R7 wake latency 1");
            step();
            chk_state(2, "R7 wake latency 2");
         end
         step();
         ext_rst = 0; wdg_rst = 0; alarm_evt = 0;
         chk_state(3, "R7 standby exit");
         check(sb_flag == 1, "R9 flag set", sb_flag, 1);
         ride_recovery();
         check(sb_flag == 1, "R9 flag survives domain reset", sb_flag, 1);
         wake_pin = 0;
         repeat (3) step();
         clear_flag();
      end

      // R7 wake rise in RUN ignored
      wake_pin = 1;
      repeat (5) step();
      chk_state(0, "R7 wake ignored in RUN");
      check(dom_rst == 0, "R7 no reset from RUN wake", dom_rst, 0);
      // R7 pin already high at entry: no wake
      enter(1'b0, 1'b1, 1'b0);
      repeat (5) step();
      chk_state(2, "R7 high pin is not a wake");
      wake_pin = 0;
      repeat (3) step();
      chk_state(2, "R7 falling pin is not a wake");
      wake_pin = 1;
      repeat (3) step();
      chk_state(3, "R7 fresh rise wakes");
      ride_recovery();
      wake_pin = 0;

      // R9 flag survives a later reset from RUN, cleared by power-on reset
      go_home();
      check(sb_flag == 1, "R9 flag survives RUN reset", sb_flag, 1);
      por_n = 0;
      step();
      por_n = 1;
      step();
      check(sb_flag == 0, "R9 por clears flag", sb_flag, 0);
      chk_state(0, "R1 state after por");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule